// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

This block keeps a 64-bit time-of-day count in whole nanoseconds for a precision time protocol clock. On every core clock cycle it adds a programmable increment. The increment has an integer nanosecond part and a 32-bit binary fraction. A fraction accumulator carries into the count, so periods that are not a whole number of nanoseconds show no long-term drift. The current time is driven out on a registered bus for use by timestamp capture logic.

Software reaches the counter through a small 32-bit register port. The port has a control register that holds the run enable, two time words and two increment words. A time read, a time write and an increment write each span two accesses. Latching and commit rules make each of them atomic.

Top module: `ns_time_counter`

## Requirements
- R1: After synchronous reset, the time, the fraction accumulator and the increment are zero, the enable bit is clear, and `reg_rdata_o` is zero.
- R2: While the enable bit (bit 0 of the control register at address 0) is clear, the time holds its value.
- R3: While enabled, each cycle adds the integer increment plus the carry out of the 32-bit fraction accumulator to the time. The fraction is held in address 3 in units of 2^-32 ns, and the integer nanoseconds in bits 7:0 of address 4. Examples: {1, 0x99999999} gives 7 ns over 5 cycles, {3, 0x33333333} gives 31 ns over 10 cycles, and {0x20, 0} gives exactly 32 ns per cycle.
- R4: An increment of zero stops the clock, and the time holds even while enabled.
- R5: A read of the low time word (address 1) returns the low 32 bits and captures the full 64-bit time. A later read of the high time word (address 2) returns the captured upper half, not the live one.
- R6: A write to address 1 only stages the low time word. A write to address 2 loads {written word, staged word} into the time at that clock edge, clears the fraction accumulator, and adds no increment in that cycle.
- R7: A write to address 3 only stages the fraction and leaves the active increment unchanged. A write to address 4 commits {bits 7:0, staged fraction} as the new increment.
- R8: A read asserted in one cycle returns its data on `reg_rdata_o` in the next cycle. Addresses 0, 3 and 4 read back the enable bit, the committed fraction and the committed integer part. `reg_rdata_o` holds its value between reads.
- R9: The time carries from the low 32 bits into the high 32 bits with no wrap handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address (0 control, 1 time low, 2 time high, 3 increment fraction, 4 increment integer) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid one cycle after the read strobe |
| time_o | output | 64 | Current time in nanoseconds |

## Verification
The bench targets the fraction carry with non-integer periods. A design that drops the carry or keeps a stale fraction across a load ends up a nanosecond or more off after a few cycles. It reads the high time word several cycles after the low word, at the point where the count has just crossed 2^32. A design without a snapshot returns the live upper half there, and a design with a narrow count wraps. Half-written increments and time words are checked for leaking into the live state before their commit word arrives. A time load is checked for adding an increment in its own cycle.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_TLO  = 3'd1,
    A_THI  = 3'd2,
    A_ILO  = 3'd3,
    A_IHI  = 3'd4
  } ptc_addr_e;
endpackage

// File: rtl/ptc_regif.sv
module ptc_regif
  import ptc_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int INT_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic [TIME_W-1:0]    time_i,
  output logic [REG_W-1:0]     rdata_o,
  output logic                 en_o,
  output logic [INT_W-1:0]     inc_int_o,
  output logic [REG_W-1:0]     inc_frac_o,
  output logic                 load_o,
  output logic [TIME_W-1:0]    load_val_o
);
  localparam int HI_W = TIME_W - REG_W;

  ptc_addr_e          a;
  logic [REG_W-1:0]   tlo_stage_q;
  logic [REG_W-1:0]   ilo_stage_q;
  logic [HI_W-1:0]    snap_hi_q;

  assign a          = ptc_addr_e'(addr_i);
  assign load_o     = wr_i && (a == A_THI);
  assign load_val_o = {wdata_i[HI_W-1:0], tlo_stage_q};

  // writes: staging words and committed control state
  always_ff @(posedge clk) begin
    if (rst) begin
      en_o        <= 1'b0;
      tlo_stage_q <= '0;
      ilo_stage_q <= '0;
      inc_int_o   <= '0;
      inc_frac_o  <= '0;
    end else if (wr_i) begin
      case (a)
        A_CTRL: en_o        <= wdata_i[0];
        A_TLO:  tlo_stage_q <= wdata_i;
        A_ILO:  ilo_stage_q <= wdata_i;
        A_IHI: begin
          inc_int_o  <= wdata_i[INT_W-1:0];
          inc_frac_o <= ilo_stage_q;
        end
        default: ;
      endcase
    end
  end

  // reads: registered data, snapshot on low time word
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o   <= '0;
      snap_hi_q <= '0;
    end else if (rd_i) begin
      case (a)
        A_CTRL:  rdata_o <= {{(REG_W-1){1'b0}}, en_o};
        A_TLO: begin
          rdata_o   <= time_i[REG_W-1:0];
          snap_hi_q <= time_i[TIME_W-1:REG_W];
        end
        A_THI:   rdata_o <= snap_hi_q;
        A_ILO:   rdata_o <= inc_frac_o;
        A_IHI:   rdata_o <= {{(REG_W-INT_W){1'b0}}, inc_int_o};
        default: rdata_o <= '0;
      endcase
    end
  end

  // R7
  inc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_i && a == A_IHI) |=> ($stable(inc_int_o) && $stable(inc_frac_o)));

  // R5
  snap_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && a == A_TLO) |=> (snap_hi_q == $past(time_i[TIME_W-1:REG_W])));
endmodule

// File: rtl/ptc_accum.sv
module ptc_accum
  import ptc_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int INT_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic [INT_W-1:0]   inc_int_i,
  input  logic [REG_W-1:0]   inc_frac_i,
  input  logic               load_i,
  input  logic [TIME_W-1:0]  load_val_i,
  output logic [TIME_W-1:0]  time_o
);
  logic [REG_W-1:0] frac_q;
  logic [REG_W:0]   fsum;

  assign fsum = {1'b0, frac_q} + {1'b0, inc_frac_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      time_o <= '0;
      frac_q <= '0;
    end else if (load_i) begin
      time_o <= load_val_i;
      frac_q <= '0;
    end else if (en_i) begin
      frac_q <= fsum[REG_W-1:0];
      time_o <= time_o + TIME_W'(inc_int_i) + TIME_W'(fsum[REG_W]);
    end
  end

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !en_i) |=> $stable(time_o));

  // R4
  zero_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && inc_int_i == '0 && inc_frac_i == '0) |=> $stable(time_o));

  // R6
  load_exact_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (time_o == $past(load_val_i) && frac_q == '0));

  // R3
  monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && en_i) |=> (time_o >= $past(time_o)));
endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter
  import ptc_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int INT_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic [TIME_W-1:0]  time_o
);
  logic               en;
  logic [INT_W-1:0]   inc_int;
  logic [REG_W-1:0]   inc_frac;
  logic               load;
  logic [TIME_W-1:0]  load_val;

  ptc_regif #(.TIME_W(TIME_W), .INT_W(INT_W)) u_regif (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .time_i     (time_o),
    .rdata_o    (reg_rdata_o),
    .en_o       (en),
    .inc_int_o  (inc_int),
    .inc_frac_o (inc_frac),
    .load_o     (load),
    .load_val_o (load_val)
  );

  ptc_accum #(.TIME_W(TIME_W), .INT_W(INT_W)) u_accum (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en),
    .inc_int_i  (inc_int),
    .inc_frac_i (inc_frac),
    .load_i     (load),
    .load_val_i (load_val),
    .time_o     (time_o)
  );
endmodule

// File: tb/ns_time_counter_test.sv
`timescale 1ns/1ps
module ns_time_counter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] tm;

  int n_tests = 0, n_fail = 0;
  string cur_tag = "R1";
  bit started = 0;

  ns_time_counter uut (
    .clk(clk), .rst(rst), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .time_o(tm)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model
  bit [63:0] m_ns, m_snap, old, s;
  bit [31:0] m_frac, m_tstg, m_istg, m_ifrac, m_rd;
  bit [7:0]  m_iint;
  bit        m_en;

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_ns = 0; m_frac = 0; m_tstg = 0; m_istg = 0; m_ifrac = 0;
      m_iint = 0; m_en = 0; m_rd = 0; m_snap = 0;
    end else begin
      old = m_ns;
      if (wr && addr == 3'd2) begin
        m_ns = {wdata, m_tstg}; m_frac = 0;
      end else if (m_en) begin
        s = {32'd0, m_frac} + {32'd0, m_ifrac};
        m_ns = m_ns + {56'd0, m_iint} + (s >> 32);
        m_frac = s[31:0];
      end
      if (rd) begin
        case (addr)
          3'd0: m_rd = {31'd0, m_en};
          3'd1: begin m_snap = old; m_rd = old[31:0]; end
          3'd2: m_rd = m_snap[63:32];
          3'd3: m_rd = m_ifrac;
          3'd4: m_rd = {24'd0, m_iint};
          default: m_rd = 0;
        endcase
      end
      if (wr) begin
        case (addr)
          3'd0: m_en = wdata[0];
          3'd1: m_tstg = wdata;
          3'd3: m_istg = wdata;
          3'd4: begin m_iint = wdata[7:0]; m_ifrac = m_istg; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst) begin
      chk({cur_tag, " time"}, tm, m_ns);
      chk({"R8 rdata (", cur_tag, ")"}, {32'd0, rdata}, {32'd0, m_rd});
    end
  end

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic load_time(input logic [63:0] v);
    wreg(3'd1, v[31:0]);
    wreg(3'd2, v[63:32]);
  endtask

  task automatic set_inc(input logic [7:0] i, input logic [31:0] f);
    wreg(3'd3, f);
    wreg(3'd4, {24'd0, i});
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 time", tm, 64'd0);
    chk("R1 rdata", {32'd0, rdata}, 64'd0);
    rreg(3'd0, d); chk("R1 ctrl", {32'd0, d}, 64'd0);
    rreg(3'd4, d); chk("R1 inc int", {32'd0, d}, 64'd0);

    // R7 staging of fraction
    cur_tag = "R7";
    wreg(3'd3, 32'h99999999);
    rreg(3'd3, d); chk("R7 staged frac not live", {32'd0, d}, 64'd0);
    wreg(3'd4, 32'd1);
    rreg(3'd3, d); chk("R7 committed frac", {32'd0, d}, 64'h99999999);

    // R2 disabled holds
    cur_tag = "R2";
    repeat (8) @(negedge clk);
    chk("R2 hold while off", tm, 64'd0);

    // R3 / R6 : 1.6 ns
    cur_tag = "R3";
    wreg(3'd0, 32'd1);
    rreg(3'd0, d); chk("R8 ctrl readback", {32'd0, d}, 64'd1);
    repeat (7) @(negedge clk);
    load_time(64'd5000);
    chk("R6 load exact no add", tm, 64'd5000);
    repeat (5) @(negedge clk);
    chk("R3 1.6ns x5", tm, 64'd5007);

    // 3.2 ns
    set_inc(8'h03, 32'h33333333);
    load_time(64'd1000);
    repeat (10) @(negedge clk);
    chk("R3 3.2ns x10", tm, 64'd1031);

    // 32 ns, R9 carry, R5 snapshot
    set_inc(8'h20, 32'h0);
    rreg(3'd4, d); chk("R8 inc int readback", {32'd0, d}, 64'h20);
    cur_tag = "R9";
    load_time(64'h00000000_FFFFFF00);
    rreg(3'd1, d); chk("R5 low word", {32'd0, d}, 64'hFFFFFF20);
    repeat (10) @(negedge clk);
    chk("R9 high carry", {32'd0, tm[63:32]}, 64'd1);
    rreg(3'd2, d); chk("R5 snapshot high", {32'd0, d}, 64'd0);

    // R7 staged fraction does not change rate
    cur_tag = "R7";
    wreg(3'd3, 32'h80000000);
    t0 = tm;
    repeat (4) @(negedge clk);
    chk("R7 rate unchanged", tm - t0, 64'd128);

    // R6 staged low word alone does not load
    cur_tag = "R6";
    wreg(3'd1, 32'h12345678);
    t0 = tm;
    repeat (2) @(negedge clk);
    chk("R6 stage only", tm - t0, 64'd64);

    // R4 zero increment freezes
    cur_tag = "R4";
    set_inc(8'h00, 32'h0);
    t0 = tm;
    repeat (8) @(negedge clk);
    chk("R4 frozen", tm, t0);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule